// File: doc/BRIEF.md
# Hedged Replica Read Unit

This unit turns one logical read into several identical reads, one per replica copy of the data. Each copy sits behind its own downstream memory channel. When a read is accepted, the unit sends a request to every replica port at once, each with the address of its own copy. The first replica to answer completes the read. Answers that arrive later are taken in and thrown away. A read that lands on a channel stalled by refresh or contention therefore costs only the latency of the fastest channel.

Every read carries a sequence tag. A response is honoured only when its port has a request outstanding and its tag matches that request, so an answer left over from an earlier read is never taken as data for a newer one. With hedging switched off, a read goes to replica 0 only. Upstream, the unit accepts a new read only after every request of the previous read has been sent and has returned, and after the result has been handed over.

Control is a four-state machine. Idle waits for a read. On "accept" it moves to Wait, which holds until the "first answer" arrives. Hold presents the result until it is "handed over". The unit then goes to Idle when all replicas have answered, or to Drain, which absorbs stragglers until the "last straggler" returns and then goes back to Idle.

Top module: `hedged_read_unit`

## Requirements
- R1: One cycle after a read is accepted with `hedge_en` high, every replica port raises `dn_req_valid`, and port i presents address slice i of `up_req_addr` (bits i*AW and up).
- R2: A read accepted with `hedge_en` low raises `dn_req_valid` on port 0 only. Ports 1 and above stay idle for that whole read.
- R3: A port whose `dn_req_ready` is low keeps its request valid with the same address and tag. The other ports issue on their own ready signals regardless.
- R4: The first matching response is delivered once on `up_rsp_data` together with the replica index on `up_rsp_idx`. `up_rsp_valid` rises the cycle after that response and stays high with stable data until `up_rsp_ready` is seen.
- R5: When several matching responses arrive in the same cycle, the lowest-indexed replica wins.
- R6: Responses after the first for the same read are absorbed. `up_rsp_valid` does not rise again for that read.
- R7: A response is ignored if its tag differs from the outstanding request of its port, or if it arrives on a port with no request outstanding.
- R8: `up_req_ready` is high exactly when the unit is idle, that is, every issued request has returned and the result has been handed over.
- R9: After reset, `up_req_ready` is high, and `up_rsp_valid` and all `dn_req_valid` bits are low.
- R10: The tag on `dn_req_tag` starts at 1 for the first read after reset and increases by one, wrapping at 2^TW, for each accepted read. Every port of one read carries the same tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hedge_en | input | 1 | Sampled on accept: 1 issues to all replicas, 0 issues to replica 0 only |
| up_req_valid | input | 1 | Upstream read request valid |
| up_req_ready | output | 1 | Unit idle and able to accept a read |
| up_req_addr | input | NREP*AW | One address per replica, replica i at bits i*AW |
| up_rsp_valid | output | 1 | Read result valid |
| up_rsp_ready | input | 1 | Upstream takes the result |
| up_rsp_data | output | DW | Data from the winning replica |
| up_rsp_idx | output | IW | Index of the winning replica |
| dn_req_valid | output | NREP | Per-replica request valid |
| dn_req_ready | input | NREP | Per-replica request ready |
| dn_req_addr | output | NREP*AW | Per-replica request address |
| dn_req_tag | output | NREP*TW | Per-replica request tag |
| dn_rsp_valid | input | NREP | Per-replica response valid, always accepted |
| dn_rsp_tag | input | NREP*TW | Per-replica response tag |
| dn_rsp_data | input | NREP*DW | Per-replica response data |

## Verification
A wrong outstanding bit or tag compare shows up in one of two ways within a cycle of the offending response: a second `up_rsp_valid` pulse for a read already served, or data and an index that belong to a stale or injected response. A state machine that leaves Drain too early or too late changes `up_req_ready` in the cycle it is compared against a model of every port's outstanding requests. Winner ordering is checked on forced ties, where all ports answer in the same cycle, and on staggered delays where the highest port is fastest.

// File: rtl/hrr_pkg.sv
package hrr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_HOLD  = 2'd2,
        ST_DRAIN = 2'd3
    } hrr_state_e;
endpackage

// File: rtl/hrr_port_trk.sv
// One replica channel: holds its request until accepted, then tracks
// the single outstanding answer and matches it by tag.
module hrr_port_trk #(
    parameter int AW = 32,
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic          use_port,
    input  logic [AW-1:0] addr_in,
    input  logic [TW-1:0] tag_in,
    output logic          req_valid,
    input  logic          req_ready,
    output logic [AW-1:0] req_addr,
    output logic [TW-1:0] req_tag,
    input  logic          rsp_valid,
    input  logic [TW-1:0] rsp_tag,
    output logic          hit,
    output logic          busy_nxt
);
    logic          pend_q;
    logic          outst_q;
    logic [AW-1:0] addr_q;
    logic [TW-1:0] tag_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            outst_q <= 1'b0;
            addr_q  <= '0;
            tag_q   <= '0;
        end else if (launch) begin
            pend_q  <= use_port;
            outst_q <= 1'b0;
            addr_q  <= addr_in;
            tag_q   <= tag_in;
        end else if (pend_q && req_ready) begin
            pend_q  <= 1'b0;
            outst_q <= 1'b1;
        end else if (hit) begin
            outst_q <= 1'b0;
        end
    end

    always_comb begin
        req_valid = pend_q;
        req_addr  = addr_q;
        req_tag   = tag_q;
        hit       = rsp_valid && outst_q && (rsp_tag == tag_q);
        busy_nxt  = pend_q || (outst_q && !hit);
    end

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_tag)));

    // R7
    stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !outst_q && !launch && !(pend_q && req_ready)) |=> !outst_q);
endmodule

// File: rtl/hrr_first_pick.sv
// Lowest-index winner among replicas answering in the same cycle.
module hrr_first_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  hits,
    output logic          any_hit,
    output logic [IW-1:0] win_idx,
    output logic [N-1:0]  win_oh
);
    always_comb begin
        any_hit = |hits;
        win_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) win_idx = IW'(i);
        end
        win_oh = hits & ~(hits - N'(1));
    end
endmodule

// File: rtl/hedged_read_unit.sv
module hedged_read_unit
    import hrr_pkg::*;
#(
    parameter int NREP = 4,
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int TW   = 4,
    parameter int IW   = (NREP > 1) ? $clog2(NREP) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hedge_en,
    input  logic               up_req_valid,
    output logic               up_req_ready,
    input  logic [NREP*AW-1:0] up_req_addr,
    output logic               up_rsp_valid,
    input  logic               up_rsp_ready,
    output logic [DW-1:0]      up_rsp_data,
    output logic [IW-1:0]      up_rsp_idx,
    output logic [NREP-1:0]    dn_req_valid,
    input  logic [NREP-1:0]    dn_req_ready,
    output logic [NREP*AW-1:0] dn_req_addr,
    output logic [NREP*TW-1:0] dn_req_tag,
    input  logic [NREP-1:0]    dn_rsp_valid,
    input  logic [NREP*TW-1:0] dn_rsp_tag,
    input  logic [NREP*DW-1:0] dn_rsp_data
);
    hrr_state_e     state_q, state_nxt;
    logic [TW-1:0]  tag_q;
    logic [TW-1:0]  tag_nxt;
    logic           launch;
    logic           hedge_q;
    logic [NREP-1:0] hits;
    logic [NREP-1:0] busy_nxt;
    logic           all_idle;
    logic           any_hit;
    logic [IW-1:0]  win_idx;
    logic [NREP-1:0] win_oh;
    logic [DW-1:0]  sel_data;
    logic [DW-1:0]  data_q;
    logic [IW-1:0]  idx_q;

    assign tag_nxt = tag_q + TW'(1);

    generate
        for (genvar g = 0; g < NREP; g++) begin : g_port
            hrr_port_trk #(.AW(AW), .TW(TW)) u_trk (
                .clk       (clk),
                .rst_n     (rst_n),
                .launch    (launch),
                .use_port  (hedge_en || (g == 0)),
                .addr_in   (up_req_addr[g*AW +: AW]),
                .tag_in    (tag_nxt),
                .req_valid (dn_req_valid[g]),
                .req_ready (dn_req_ready[g]),
                .req_addr  (dn_req_addr[g*AW +: AW]),
                .req_tag   (dn_req_tag[g*TW +: TW]),
                .rsp_valid (dn_rsp_valid[g]),
                .rsp_tag   (dn_rsp_tag[g*TW +: TW]),
                .hit       (hits[g]),
                .busy_nxt  (busy_nxt[g])
            );
        end
    endgenerate

    hrr_first_pick #(.N(NREP), .IW(IW)) u_pick (
        .hits    (hits),
        .any_hit (any_hit),
        .win_idx (win_idx),
        .win_oh  (win_oh)
    );

    always_comb begin
        sel_data = '0;
        for (int i = 0; i < NREP; i++) begin
            if (win_oh[i]) sel_data = sel_data | dn_rsp_data[i*DW +: DW];
        end
    end

    assign all_idle = ~|busy_nxt;

    // Next-state logic
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE:  if (up_req_valid) state_nxt = ST_WAIT;
            ST_WAIT:  if (any_hit)      state_nxt = ST_HOLD;
            ST_HOLD:  if (up_rsp_ready) state_nxt = all_idle ? ST_IDLE : ST_DRAIN;
            ST_DRAIN: if (all_idle)     state_nxt = ST_IDLE;
        endcase
    end

    // State register and per-read registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tag_q   <= '0;
            hedge_q <= 1'b0;
            data_q  <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_nxt;
            if (launch) begin
                tag_q   <= tag_nxt;
                hedge_q <= hedge_en;
            end
            if ((state_q == ST_WAIT) && any_hit) begin
                data_q <= sel_data;
                idx_q  <= win_idx;
            end
        end
    end

    // Outputs
    always_comb begin
        up_req_ready = (state_q == ST_IDLE);
        up_rsp_valid = (state_q == ST_HOLD);
        launch       = up_req_ready && up_req_valid;
        up_rsp_data  = data_q;
        up_rsp_idx   = idx_q;
    end

    // R2
    single_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hedge_q && (state_q != ST_IDLE)) |-> ($countones(dn_req_valid) <= 1 && !(|(dn_req_valid >> 1))));

    // R4
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_rsp_valid && !up_rsp_ready) |=> (up_rsp_valid && $stable(up_rsp_data) && $stable(up_rsp_idx)));

    // R5
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_oh));

    // R5
    tie_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WAIT) && hits[0]) |=> (up_rsp_idx == '0));

    // R6
    one_delivery_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_rsp_valid && up_rsp_ready) |=> !up_rsp_valid);

    // R8
    accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_req_valid && up_req_ready) |-> (dn_req_valid == '0 && !up_rsp_valid));

    // R10
    tag_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (dn_req_tag[TW-1:0] == $past(tag_q) + TW'(1)));
endmodule

// File: tb/sim_hedged_read_unit.sv
module sim_hedged_read_unit;
    localparam int CLK_NS = 10;
    localparam int NREP = 4;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int TW = 4;
    localparam int IW = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               hedge_en = 1'b0;
    logic               up_req_valid = 1'b0;
    logic               up_req_ready;
    logic [NREP*AW-1:0] up_req_addr = '0;
    logic               up_rsp_valid;
    logic               up_rsp_ready = 1'b0;
    logic [DW-1:0]      up_rsp_data;
    logic [IW-1:0]      up_rsp_idx;
    logic [NREP-1:0]    dn_req_valid;
    logic [NREP-1:0]    dn_req_ready = '0;
    logic [NREP*AW-1:0] dn_req_addr;
    logic [NREP*TW-1:0] dn_req_tag;
    logic [NREP-1:0]    dn_rsp_valid = '0;
    logic [NREP*TW-1:0] dn_rsp_tag = '0;
    logic [NREP*DW-1:0] dn_rsp_data = '0;

    hedged_read_unit #(.NREP(NREP), .AW(AW), .DW(DW), .TW(TW), .IW(IW)) u0 (.*);

    always #(CLK_NS/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model of the unit
    bit m_active = 0, m_won = 0, m_deliv = 0, m_hedge = 0, m_tie = 0;
    bit m_pend [NREP];
    bit m_out  [NREP];
    bit m_wait [NREP];
    int m_dly  [NREP];
    logic [AW-1:0] m_addr [NREP];
    logic [TW-1:0] m_tag = '0;
    logic [DW-1:0] m_data = '0;
    int m_idx = 0;
    int ties_seen = 0, bogus_sent = 0, served = 0, winner3 = 0;

    // phase knobs
    int ph_hedge, ph_dly, ph_rdy, ph_req, ph_ursp, ph_bogus;

    function automatic logic [DW-1:0] data_f(logic [AW-1:0] a, int i);
        logic [31:0] k;
        k = 32'h9E37_79B9 * 32'(i + 1);
        return a ^ k;
    endfunction

    function automatic int dly_for(int i);
        if (ph_dly == 0) return 0;
        if (ph_dly == 1) return NREP - 1 - i;
        return int'($urandom % 6);
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        bit real_r [NREP];
        bit pre_active, pre_hold, anyr, idle;
        int nreal;
        string rq;
        @(negedge clk);
        // ---- checks against model state after the previous edge
        chk(up_req_ready == !m_active, "R8", "up_req_ready", 64'(up_req_ready), 64'(!m_active));
        for (int i = 0; i < NREP; i++) begin
            if (m_wait[i]) rq = "R3";
            else if (i > 0 && !m_hedge) rq = "R2";
            else rq = "R1";
            chk(dn_req_valid[i] == m_pend[i], rq, $sformatf("dn_req_valid[%0d]", i),
                64'(dn_req_valid[i]), 64'(m_pend[i]));
            if (m_pend[i] && dn_req_valid[i]) begin
                chk(dn_req_addr[i*AW +: AW] == m_addr[i], m_wait[i] ? "R3" : "R1",
                    $sformatf("dn_req_addr[%0d]", i), 64'(dn_req_addr[i*AW +: AW]), 64'(m_addr[i]));
                chk(dn_req_tag[i*TW +: TW] == m_tag, "R10", $sformatf("dn_req_tag[%0d]", i),
                    64'(dn_req_tag[i*TW +: TW]), 64'(m_tag));
            end
        end
        chk(up_rsp_valid == (m_won && !m_deliv), m_deliv ? "R6" : "R4", "up_rsp_valid",
            64'(up_rsp_valid), 64'(m_won && !m_deliv));
        if (up_rsp_valid && m_won && !m_deliv) begin
            chk(up_rsp_data == m_data, "R4", "up_rsp_data", 64'(up_rsp_data), 64'(m_data));
            chk(int'(up_rsp_idx) == m_idx, m_tie ? "R5" : "R4", "up_rsp_idx",
                64'(up_rsp_idx), 64'(m_idx));
        end
        // ---- drives for the coming edge
        hedge_en = (ph_hedge == 2) ? 1'($urandom % 2) : 1'(ph_hedge);
        up_req_valid = (($urandom % 100) < ph_req);
        for (int i = 0; i < NREP; i++) up_req_addr[i*AW +: AW] = $urandom;
        up_rsp_ready = (($urandom % 100) < ph_ursp);
        nreal = 0;
        for (int i = 0; i < NREP; i++) begin
            dn_req_ready[i] = (($urandom % 100) < ph_rdy);
            real_r[i] = m_out[i] && (m_dly[i] == 0);
            if (real_r[i]) begin
                nreal++;
                dn_rsp_valid[i] = 1'b1;
                dn_rsp_tag[i*TW +: TW] = m_tag;
                dn_rsp_data[i*DW +: DW] = data_f(m_addr[i], i);
            end else if (($urandom % 100) < ph_bogus) begin
                // R7: stale or foreign tag, or no request outstanding
                bogus_sent++;
                dn_rsp_valid[i] = 1'b1;
                dn_rsp_tag[i*TW +: TW] = m_out[i] ? m_tag + TW'(1 + ($urandom % 15))
                                                  : TW'($urandom);
                dn_rsp_data[i*DW +: DW] = $urandom;
            end else begin
                dn_rsp_valid[i] = 1'b0;
            end
        end
        // ---- model update for the coming edge
        pre_active = m_active;
        pre_hold = m_won && !m_deliv;
        if (pre_hold && up_rsp_ready) begin
            m_deliv = 1;
            served++;
        end
        anyr = (nreal > 0);
        if (m_active && !m_won && anyr) begin
            m_won = 1;
            m_tie = (nreal > 1);
            if (m_tie) ties_seen++;
            m_idx = -1;
            for (int i = NREP - 1; i >= 0; i--) if (real_r[i]) m_idx = i;
            if (m_idx == NREP - 1) winner3++;
            m_data = data_f(m_addr[m_idx], m_idx);
        end
        for (int i = 0; i < NREP; i++) begin
            if (real_r[i]) m_out[i] = 0;
            else if (m_out[i]) m_dly[i]--;
            if (m_pend[i] && dn_req_ready[i]) begin
                m_pend[i] = 0;
                m_out[i] = 1;
                m_dly[i] = dly_for(i);
                m_wait[i] = 0;
            end else begin
                m_wait[i] = m_pend[i];
            end
        end
        idle = 1;
        for (int i = 0; i < NREP; i++) if (m_pend[i] || m_out[i]) idle = 0;
        if (m_active && m_deliv && idle) m_active = 0;
        if (!pre_active && up_req_valid) begin
            m_active = 1;
            m_tag = m_tag + TW'(1);
            m_won = 0;
            m_deliv = 0;
            m_tie = 0;
            m_hedge = hedge_en;
            for (int i = 0; i < NREP; i++) begin
                m_addr[i] = up_req_addr[i*AW +: AW];
                m_pend[i] = hedge_en || (i == 0);
                m_wait[i] = 0;
            end
        end
    endtask

    task automatic run_phase(int h, int d, int r, int q, int u, int b, int n);
        ph_hedge = h; ph_dly = d; ph_rdy = r; ph_req = q; ph_ursp = u; ph_bogus = b;
        for (int c = 0; c < n; c++) step();
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < NREP; i++) begin
            m_pend[i] = 0; m_out[i] = 0; m_wait[i] = 0; m_dly[i] = 0; m_addr[i] = '0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(up_req_ready == 1'b1, "R9", "up_req_ready after reset", 64'(up_req_ready), 64'd1);
        chk(up_rsp_valid == 1'b0, "R9", "up_rsp_valid after reset", 64'(up_rsp_valid), 64'd0);
        chk(dn_req_valid == '0, "R9", "dn_req_valid after reset", 64'(dn_req_valid), 64'd0);
        // R5 forced ties, then R4 staggered with highest port fastest
        run_phase(1, 0, 100, 100, 100, 0, 200);
        run_phase(1, 1, 100, 100, 100, 0, 200);
        // R2 single-replica mode with stray responses
        run_phase(0, 2, 70, 80, 70, 30, 400);
        // mixed random traffic, R3 backpressure, R7 injected responses
        run_phase(2, 2, 50, 60, 50, 40, 3000);
        run_phase(1, 2, 30, 70, 20, 50, 2000);
        // drain
        run_phase(1, 2, 100, 0, 100, 0, 60);
        chk(up_req_ready == 1'b1, "R8", "idle at end", 64'(up_req_ready), 64'd1);
        chk(ties_seen > 0, "R5", "tie cases seen", 64'(ties_seen), 64'd1);
        chk(winner3 > 0, "R4", "highest-port wins seen", 64'(winner3), 64'd1);
        chk(bogus_sent > 0, "R7", "stray responses injected", 64'(bogus_sent), 64'd1);
        chk(served > 100, "R6", "reads served", 64'(served), 64'd101);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            errors++;
            $display("FAIL R8 watchdog expired actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule